// File: doc/BRIEF.md
# Filter Gatekeeper

The gatekeeper decides, for each of up to four transaction filters, whether new traffic may enter. Software sets an open request per filter through a single control word. The block answers with an actual gate state in a separate read-only field of the same word. Software is expected to poll that field until it matches what it asked for.

The actual state of a filter only moves to its requested value once the filter has drained. A filter has drained when its count of in-flight transactions is zero. The block keeps that count itself: it adds one for every transaction it accepts and subtracts one for every completion reported to it.

A new transaction on a filter is accepted only while the gate is open, no close is pending and the count has room. A transaction that is not accepted is stalled by the requester and offered again later. Transactions that were already accepted complete normally while a close is pending.

Top module: `filter_gatekeeper`

## Requirements
- R1: After reset every request bit and every status bit is 0, reg_rdata reads 0, and no transaction is accepted on any filter.
- R2: A cycle with reg_we high stores reg_wdata bits [NUM_FILT-1:0] as the open requests (bit i belongs to filter i). From the next cycle the stored value reads back on reg_rdata bits [NUM_FILT-1:0].
- R3: The status field sits in reg_rdata bits [16+NUM_FILT-1:16] (bit 16+i belongs to filter i) and cannot be written: writing ones to those bit positions changes no status. All reg_rdata bits outside the request and status fields read 0.
- R4: When a filter has no transactions in flight, its status bit takes the value of its request bit on the clock edge after the request is stored.
- R5: While a filter has one or more transactions in flight, its status bit keeps its previous value. It takes the requested value on the edge after the count reaches zero.
- R6: txn_accept[i] is high only when txn_req[i] is high and filter i is both requested open and reported open. A closed gate, or an open gate with a close pending, stalls new transactions.
- R7: Completions (txn_done) still lower the count while a close is pending, so a pending close always finishes once every accepted transaction has completed.
- R8: When a filter's in-flight count is at its maximum of 2^CNT_W-1, no new transaction is accepted on that filter until a completion frees a slot.
- R9: A completion reported on a filter whose count is already zero is ignored; the count never wraps below zero.
- R10: Filters are independent: the drain state of one filter never delays a status change on another.
- R11: If a filter is requested open again while its close is still pending, its status stays open and acceptance resumes as soon as the request is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; deassertion is synchronised inside the block |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data; bits [NUM_FILT-1:0] are the open requests |
| reg_rdata | output | 32 | Control word readback: requests at [NUM_FILT-1:0], status at [16+NUM_FILT-1:16] |
| txn_req | input | NUM_FILT | A new transaction is offered on filter i |
| txn_done | input | NUM_FILT | A previously accepted transaction on filter i has completed |
| txn_accept | output | NUM_FILT | The offered transaction on filter i is accepted this cycle; low means stall |

## Verification
The assertions assume that txn_done is reported only for a transaction the block has accepted and that has not yet completed. Under that assumption the internal count matches the traffic that is really in flight. The one exception is the underflow scenario. It raises txn_done deliberately on an empty filter to confirm that the count stays at zero. It then checks the result through the delay of a later close. In every other scenario the stimulus raises completions only against transactions the bench has counted as accepted. The stimulus also holds each request and completion input steady across a clock edge, so each edge sees exactly one value.

// File: rtl/gk_pkg.sv
package gk_pkg;
  localparam int unsigned GK_MAX_FILT = 4;
  localparam int unsigned GK_WORD_W   = 32;
  localparam int unsigned GK_REQ_LSB  = 0;
  localparam int unsigned GK_STAT_LSB = 16;
endpackage

// File: rtl/gk_txn_counter.sv
module gk_txn_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic idle,
  output logic full
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             dec_eff;
  logic             cnt_en;

  // a completion against an empty count is dropped
  assign dec_eff = dec && (cnt_q != '0);
  assign cnt_en  = inc ^ dec_eff;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec_eff)      cnt_d = cnt_q + CNT_ONE;
    else if (dec_eff && !inc) cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign idle = (cnt_q == '0);
  assign full = (cnt_q == CNT_MAX);
endmodule

// File: rtl/gk_gate_cell.sv
module gk_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic drained,
  input  logic cnt_full,
  input  logic txn_req,
  output logic gate_open,
  output logic txn_accept
);
  logic stat_q;
  logic stat_d;
  logic stat_en;

  // status moves toward the request only with nothing in flight
  assign stat_en = drained && (open_req != stat_q);
  assign stat_d  = open_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign gate_open  = stat_q;
  assign txn_accept = txn_req && open_req && stat_q && !cnt_full;
endmodule

// File: rtl/gk_reg_port.sv
module gk_reg_port
  import gk_pkg::*;
#(
  parameter int unsigned NUM_FILT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [GK_WORD_W-1:0] reg_wdata,
  input  logic [NUM_FILT-1:0]  gate_stat,
  output logic [NUM_FILT-1:0]  open_req,
  output logic [GK_WORD_W-1:0] reg_rdata
);
  logic [NUM_FILT-1:0] req_q;
  logic [NUM_FILT-1:0] req_d;
  logic                wdata_unused;

  assign req_d        = reg_wdata[GK_REQ_LSB +: NUM_FILT];
  assign wdata_unused = ^reg_wdata[GK_WORD_W-1:NUM_FILT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (reg_we) req_q <= req_d;
  end

  always_comb begin
    reg_rdata                           = '0;
    reg_rdata[GK_REQ_LSB  +: NUM_FILT]  = req_q;
    reg_rdata[GK_STAT_LSB +: NUM_FILT]  = gate_stat;
  end

  assign open_req = req_q;
endmodule

// File: rtl/filter_gatekeeper.sv
module filter_gatekeeper
  import gk_pkg::*;
#(
  parameter int unsigned NUM_FILT = 4,
  parameter int unsigned CNT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [GK_WORD_W-1:0] reg_wdata,
  output logic [GK_WORD_W-1:0] reg_rdata,
  input  logic [NUM_FILT-1:0]  txn_req,
  input  logic [NUM_FILT-1:0]  txn_done,
  output logic [NUM_FILT-1:0]  txn_accept
);
  logic [1:0]          rst_sync_q;
  logic                rst_sync_n;
  logic [NUM_FILT-1:0] open_req;
  logic [NUM_FILT-1:0] gate_stat;
  logic [NUM_FILT-1:0] drained;
  logic [NUM_FILT-1:0] cnt_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  gk_reg_port #(.NUM_FILT(NUM_FILT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .gate_stat (gate_stat),
    .open_req  (open_req),
    .reg_rdata (reg_rdata)
  );

  for (genvar gi = 0; gi < NUM_FILT; gi++) begin : g_filt
    gk_txn_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .inc   (txn_accept[gi]),
      .dec   (txn_done[gi]),
      .idle  (drained[gi]),
      .full  (cnt_full[gi])
    );

    gk_gate_cell u_gate (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .open_req   (open_req[gi]),
      .drained    (drained[gi]),
      .cnt_full   (cnt_full[gi]),
      .txn_req    (txn_req[gi]),
      .gate_open  (gate_stat[gi]),
      .txn_accept (txn_accept[gi])
    );
  end
endmodule

// File: rtl/gk_checker.sv
module gk_checker
  import gk_pkg::*;
#(
  parameter int unsigned NUM_FILT = 4
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 reg_we,
  input logic [GK_WORD_W-1:0] reg_wdata,
  input logic [GK_WORD_W-1:0] reg_rdata,
  input logic [NUM_FILT-1:0]  open_req,
  input logic [NUM_FILT-1:0]  gate_stat,
  input logic [NUM_FILT-1:0]  drained,
  input logic [NUM_FILT-1:0]  cnt_full,
  input logic [NUM_FILT-1:0]  txn_done,
  input logic [NUM_FILT-1:0]  txn_accept
);
  localparam logic [GK_WORD_W-1:0] FIELD_MASK =
    (((GK_WORD_W)'(1) << NUM_FILT) - 1) |
    ((((GK_WORD_W)'(1) << NUM_FILT) - 1) << GK_STAT_LSB);

  // R3
  rdata_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rdata & ~FIELD_MASK) == '0);

  // R2
  req_store_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we |=> open_req == $past(reg_wdata[NUM_FILT-1:0]));

  for (genvar gi = 0; gi < NUM_FILT; gi++) begin : g_chk
    // R5
    stat_drain_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !$stable(gate_stat[gi]) |-> $past(drained[gi]));

    // R4
    stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !$stable(gate_stat[gi]) |-> gate_stat[gi] == $past(open_req[gi]));

    // R6
    accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      txn_accept[gi] |-> (open_req[gi] && gate_stat[gi]));

    // R8
    accept_room_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      txn_accept[gi] |-> !cnt_full[gi]);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (drained[gi] && txn_done[gi] && !txn_accept[gi]) |=> drained[gi]);
  end
endmodule

bind filter_gatekeeper gk_checker #(.NUM_FILT(NUM_FILT)) u_gk_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .reg_we     (reg_we),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .open_req   (open_req),
  .gate_stat  (gate_stat),
  .drained    (drained),
  .cnt_full   (cnt_full),
  .txn_done   (txn_done),
  .txn_accept (txn_accept)
);

// File: tb/tb_filter_gatekeeper.sv
`timescale 1ns/1ps
module tb_filter_gatekeeper;
  localparam int NF = 4;

  logic          clk;
  logic          rst_n;
  logic          reg_we;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [NF-1:0] txn_req;
  logic [NF-1:0] txn_done;
  logic [NF-1:0] txn_accept;

  int n_checks;
  int n_fails;

  filter_gatekeeper #(.NUM_FILT(NF), .CNT_W(4)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .txn_req    (txn_req),
    .txn_done   (txn_done),
    .txn_accept (txn_accept)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // inputs change 2 ns after a rising edge
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [31:0] v);
    reg_we = 1'b1;
    reg_wdata = v;
    tick();
    reg_we = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    reg_we = 1'b0;
    reg_wdata = '0;
    txn_req = '0;
    txn_done = '0;
    tick();
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rdata after reset", reg_rdata, 32'h0);
    txn_req = 4'hF;
    #1 check("R1 no accept after reset", {28'h0, txn_accept}, 32'h0);
    txn_req = '0;
  endtask

  task automatic t_status_ro();
    do_reset();
    wr(32'h000F_0000);
    tick();
    check("R3 status write ignored", reg_rdata, 32'h0);
    wr(32'hFFF0_FFF5);
    check("R3 only request bits stored", reg_rdata, 32'h0000_0005);
  endtask

  task automatic t_open_close_drain();
    do_reset();
    wr(32'h1);
    check("R2 request readback", reg_rdata, 32'h0000_0001);
    tick();
    check("R4 status follows open", reg_rdata, 32'h0001_0001);
    txn_req = 4'h1;
    #1 check("R6 accept when open", {28'h0, txn_accept}, 32'h1);
    repeat (3) tick();
    txn_req = '0;
    wr(32'h0);
    check("R5 close held while busy", reg_rdata, 32'h0001_0000);
    txn_req = 4'h1;
    #1 check("R6 stall while close pending", {28'h0, txn_accept}, 32'h0);
    txn_req = '0;
    tick();
    tick();
    check("R5 still held", reg_rdata, 32'h0001_0000);
    txn_done = 4'h1;
    repeat (3) tick();
    txn_done = '0;
    check("R5 held on edge count reaches zero", reg_rdata, 32'h0001_0000);
    tick();
    check("R7 close completes after drain", reg_rdata, 32'h0);
    txn_req = 4'h1;
    #1 check("R6 stall when closed", {28'h0, txn_accept}, 32'h0);
    txn_req = '0;
  endtask

  task automatic t_saturate();
    do_reset();
    wr(32'h2);
    tick();
    txn_req = 4'h2;
    repeat (15) tick();
    #1 check("R8 no accept at full count", {28'h0, txn_accept}, 32'h0);
    txn_done = 4'h2;
    tick();
    txn_done = '0;
    #1 check("R8 accept after a slot frees", {28'h0, txn_accept}, 32'h2);
    txn_req = '0;
  endtask

  task automatic t_underflow();
    do_reset();
    txn_done = 4'h4;
    tick();
    tick();
    txn_done = '0;
    wr(32'h4);
    tick();
    txn_req = 4'h4;
    tick();
    txn_req = '0;
    wr(32'h0);
    tick();
    check("R9 count did not wrap", reg_rdata, 32'h0004_0000);
    txn_done = 4'h4;
    tick();
    txn_done = '0;
    tick();
    check("R9 closes after one completion", reg_rdata, 32'h0);
  endtask

  task automatic t_reopen();
    do_reset();
    wr(32'h8);
    tick();
    txn_req = 4'h8;
    tick();
    wr(32'h0);
    #1 check("R11 stall while close pending", {28'h0, txn_accept}, 32'h0);
    wr(32'h8);
    #1 check("R11 accept resumes on reopen", {28'h0, txn_accept}, 32'h8);
    check("R11 status stayed open", reg_rdata, 32'h0008_0008);
    txn_req = '0;
  endtask

  task automatic t_independent();
    do_reset();
    wr(32'hF);
    tick();
    check("R10 all open", reg_rdata, 32'h000F_000F);
    txn_req = 4'h1;
    tick();
    txn_req = '0;
    wr(32'h0);
    tick();
    check("R10 idle filters close, busy one holds", reg_rdata, 32'h0001_0000);
  endtask

  initial begin
    n_checks = 0;
    n_fails = 0;
    rst_n = 1'b0;
    reg_we = 1'b0;
    reg_wdata = '0;
    txn_req = '0;
    txn_done = '0;
    t_reset();
    t_status_ro();
    t_open_close_drain();
    t_saturate();
    t_underflow();
    t_reopen();
    t_independent();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule